// File: doc/BRIEF.md
# Super-Pixel Hit Address Encoder

This block reads out binary pixel hits in data-driven order. The pixel field is cut into super pixels, each a small square of pixels. Every pixel has its own hit latch. A hit pulse sets the latch, and the latch stays set until the encoder has put that pixel on the output bus. Inside each super pixel an OR tree tells whether any latch is set. An empty super pixel therefore costs no readout time, and the bus only ever carries real hits.

A hit is presented as three fields:

- a one-hot column projection;
- a one-hot row projection;
- a binary super-pixel index.

With the default sizes these give a 20-line address (8 + 8 + 4). A cycle in which the address is valid and hold is low counts as a read. In that cycle the same address is decoded back into the owning super pixel, and the pixel at the crossing of the selected row and column is cleared. On the next cycle the bus moves on to the next pending hit, so each read takes one clock. A downstream hold input freezes the bus, and a synchronous clear input empties every latch.

Top module: `sp_hit_encoder`

## Requirements
- R1: A hit input bit held high for a single cycle sets that pixel's latch, and the hit is later reported on the bus even though the input has already returned low.
- R2: With hold low, k pending hits are reported in k consecutive valid cycles, once each. The cycle after a read never shows the same address again unless a new hit has arrived on that pixel.
- R3: Hit input bit index i = s*64 + r*8 + c (for the default 8 by 8 super pixel) is reported with addr_sp_o = s, addr_y_o bit r set and addr_x_o bit c set.
- R4: Pending hits are reported in order of lowest super-pixel index first, then lowest row, then lowest column. This equals ascending hit input bit index.
- R5: While valid_o is high, addr_x_o and addr_y_o each have exactly one bit set. While valid_o is low, addr_x_o, addr_y_o and addr_sp_o are all zero, and this includes the state after reset.
- R6: While valid_o and hold_i are both high, the address and valid_o stay unchanged and the shown hit is not consumed. After hold_i falls, the shown hit is read once and readout continues in order.
- R7: A new hit on a pixel that arrives in the same cycle that pixel is being read is kept, and that pixel is reported again two cycles later. The cycle in between is empty when nothing else is pending.
- R8: clr_i high for one cycle empties every latch and drops valid_o on the following cycle. A hit that arrives in the clear cycle is discarded, and nothing is reported afterwards until new hits arrive.
- R9: A hit pulse sampled at clock edge k is visible on the bus, as the only pending hit, right after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of all pixel latches and of the bus |
| hit_i | input | 1024 | Per-pixel hit pulses, bit s*64 + r*8 + c |
| hold_i | input | 1 | Downstream hold: freeze the bus and consume nothing |
| valid_o | output | 1 | The address on the bus is a hit |
| addr_x_o | output | 8 | One-hot column projection |
| addr_y_o | output | 8 | One-hot row projection |
| addr_sp_o | output | 4 | Super-pixel index |

## Verification
The hardest case to reach from the ports is a fresh hit that lands on a pixel in the very cycle the encoder is clearing it. The bench waits until that pixel appears on the bus with hold low, then drives the new pulse on that same half cycle. It then expects one empty cycle followed by the same address again. A second narrow window is a hold asserted exactly when the first of several hits is shown. The bench checks that the bus freezes and that the order resumes intact. Beyond these, every pixel is swept alone, and pseudo-random dense patterns are compared against ascending bit order.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // State of the output address register
  typedef enum logic {
    RD_EMPTY   = 1'b0,
    RD_PRESENT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/sp_reset_sync.sv
module sp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sp_pixel_group.sv
// One super pixel: hit latches, reset decode, OR-tree flag and
// row-then-column priority pick over the still-pending latches.
module sp_pixel_group #(
  parameter int COLS = 8,
  parameter int ROWS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [COLS*ROWS-1:0] hit_i,
  input  logic            rd_en_i,
  input  logic [COLS-1:0] rd_x_i,
  input  logic [ROWS-1:0] rd_y_i,
  output logic            any_o,
  output logic [COLS-1:0] x_o,
  output logic [ROWS-1:0] y_o
);
  localparam int PIX = COLS * ROWS;

  logic [PIX-1:0]  lat_q;
  logic [PIX-1:0]  lat_d;
  logic [PIX-1:0]  rst_mask;
  logic [PIX-1:0]  pend;
  logic            lat_en;
  logic [ROWS-1:0] row_any;
  logic [COLS-1:0] row_bits;

  // reset decoder: crossing of the read row and column
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign rst_mask[r*COLS+c] = rd_en_i & rd_y_i[r] & rd_x_i[c];
    end
    assign row_any[r] = |pend[r*COLS +: COLS];
  end

  assign pend   = lat_q & ~rst_mask;
  assign lat_en = clr_i | rd_en_i | (|hit_i);

  always_comb begin
    if (clr_i) lat_d = '0;
    else       lat_d = pend | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  // lowest pending row, then lowest pending column inside it
  assign y_o = row_any & (-row_any);

  always_comb begin
    row_bits = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (y_o[r]) row_bits = row_bits | pend[r*COLS +: COLS];
    end
  end

  assign x_o   = row_bits & (-row_bits);
  assign any_o = |row_any;
endmodule

// File: rtl/sp_group_arbiter.sv
// Picks the lowest-index super pixel raising its flag and muxes its projections.
module sp_group_arbiter #(
  parameter int N_GROUPS = 16,
  parameter int COLS     = 8,
  parameter int ROWS     = 8,
  localparam int GW      = $clog2(N_GROUPS)
) (
  input  logic [N_GROUPS-1:0]      any_i,
  input  logic [N_GROUPS*COLS-1:0] x_i,
  input  logic [N_GROUPS*ROWS-1:0] y_i,
  output logic                     found_o,
  output logic [GW-1:0]            idx_o,
  output logic [COLS-1:0]          x_o,
  output logic [ROWS-1:0]          y_o
);
  logic [N_GROUPS-1:0] gsel;

  assign gsel    = any_i & (-any_i);
  assign found_o = |any_i;

  always_comb begin
    idx_o = '0;
    x_o   = '0;
    y_o   = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (gsel[g]) begin
        idx_o = idx_o | GW'(g);
        x_o   = x_o | x_i[g*COLS +: COLS];
        y_o   = y_o | y_i[g*ROWS +: ROWS];
      end
    end
  end
endmodule

// File: rtl/sp_hit_encoder.sv
module sp_hit_encoder
  import sp_pkg::*;
#(
  parameter int N_GROUPS = 16,
  parameter int COLS     = 8,
  parameter int ROWS     = 8,
  localparam int PIX     = COLS * ROWS,
  localparam int GW      = $clog2(N_GROUPS),
  localparam int TOTAL   = N_GROUPS * PIX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [TOTAL-1:0] hit_i,
  input  logic             hold_i,
  output logic             valid_o,
  output logic [COLS-1:0]  addr_x_o,
  output logic [ROWS-1:0]  addr_y_o,
  output logic [GW-1:0]    addr_sp_o
);
  logic rst_q_n;

  logic [N_GROUPS-1:0]      g_any;
  logic [N_GROUPS*COLS-1:0] g_x;
  logic [N_GROUPS*ROWS-1:0] g_y;
  logic [N_GROUPS-1:0]      rd_sel;

  logic            arb_found;
  logic [GW-1:0]   arb_idx;
  logic [COLS-1:0] arb_x;
  logic [ROWS-1:0] arb_y;

  rd_state_e       state_q, state_d;
  logic [COLS-1:0] x_q, x_d;
  logic [ROWS-1:0] y_q, y_d;
  logic [GW-1:0]   sp_q, sp_d;
  logic            rd_fire;
  logic            load;
  logic            out_en;

  sp_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign rd_sel[g] = rd_fire && (sp_q == GW'(g));

    sp_pixel_group #(.COLS(COLS), .ROWS(ROWS)) u_grp (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .clr_i   (clr_i),
      .hit_i   (hit_i[g*PIX +: PIX]),
      .rd_en_i (rd_sel[g]),
      .rd_x_i  (x_q),
      .rd_y_i  (y_q),
      .any_o   (g_any[g]),
      .x_o     (g_x[g*COLS +: COLS]),
      .y_o     (g_y[g*ROWS +: ROWS])
    );
  end

  sp_group_arbiter #(.N_GROUPS(N_GROUPS), .COLS(COLS), .ROWS(ROWS)) u_arb (
    .any_i   (g_any),
    .x_i     (g_x),
    .y_i     (g_y),
    .found_o (arb_found),
    .idx_o   (arb_idx),
    .x_o     (arb_x),
    .y_o     (arb_y)
  );

  // next-state: a shown hit is consumed when hold is low
  always_comb begin
    rd_fire = (state_q == RD_PRESENT) && !hold_i && !clr_i;
    load    = !((state_q == RD_PRESENT) && hold_i);
    out_en  = clr_i | load;
    state_d = RD_EMPTY;
    x_d     = '0;
    y_d     = '0;
    sp_d    = '0;
    if (!clr_i && arb_found) begin
      state_d = RD_PRESENT;
      x_d     = arb_x;
      y_d     = arb_y;
      sp_d    = arb_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= RD_EMPTY;
      x_q     <= '0;
      y_q     <= '0;
      sp_q    <= '0;
    end else if (out_en) begin
      state_q <= state_d;
      x_q     <= x_d;
      y_q     <= y_d;
      sp_q    <= sp_d;
    end
  end

  assign valid_o   = (state_q == RD_PRESENT);
  assign addr_x_o  = x_q;
  assign addr_y_o  = y_q;
  assign addr_sp_o = sp_q;
endmodule

// File: rtl/sp_hit_encoder_chk.sv
module sp_hit_encoder_chk #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter int GW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic            hold_i,
  input logic            valid_o,
  input logic [COLS-1:0] addr_x_o,
  input logic [ROWS-1:0] addr_y_o,
  input logic [GW-1:0]   addr_sp_o
);
  AST_PROJ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($countones(addr_x_o) == 1 && $countones(addr_y_o) == 1)); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (addr_x_o == '0 && addr_y_o == '0 && addr_sp_o == '0)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && hold_i && !clr_i) |=>
      (valid_o && $stable(addr_x_o) && $stable(addr_y_o) && $stable(addr_sp_o))); // R6

  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !hold_i && !clr_i) |=>
      !(valid_o && addr_x_o == $past(addr_x_o) && addr_y_o == $past(addr_y_o)
        && addr_sp_o == $past(addr_sp_o))); // R2

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !valid_o); // R8
endmodule

bind sp_hit_encoder sp_hit_encoder_chk #(.COLS(COLS), .ROWS(ROWS), .GW(GW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .hold_i    (hold_i),
  .valid_o   (valid_o),
  .addr_x_o  (addr_x_o),
  .addr_y_o  (addr_y_o),
  .addr_sp_o (addr_sp_o)
);

// File: tb/sp_hit_encoder_test.sv
module sp_hit_encoder_test;
  localparam int NG    = 16;
  localparam int NC    = 8;
  localparam int NR    = 8;
  localparam int GW    = 4;
  localparam int TOTAL = NG * NC * NR;

  logic             clk;
  logic             rst_n;
  logic             clr_i;
  logic [TOTAL-1:0] hit_i;
  logic             hold_i;
  logic             valid_o;
  logic [NC-1:0]    addr_x_o;
  logic [NR-1:0]    addr_y_o;
  logic [GW-1:0]    addr_sp_o;

  int checks;
  int failures;
  int cyc;
  int got [0:TOTAL-1];
  int expv [0:TOTAL-1];
  int n_got;
  int n_exp;
  bit first_valid;
  logic [31:0] lf;

  sp_hit_encoder uut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .hit_i(hit_i), .hold_i(hold_i),
    .valid_o(valid_o), .addr_x_o(addr_x_o), .addr_y_o(addr_y_o), .addr_sp_o(addr_sp_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog R2 act=%0d exp=<100000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int oh_idx(input logic [7:0] v);
    int r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int cur_addr();
    return int'(addr_sp_o) * 64 + oh_idx(addr_y_o) * 8 + oh_idx(addr_x_o);
  endfunction

  task automatic sample_now(input int i);
    if (i == 0) first_valid = valid_o;
    if (valid_o) begin
      check($countones(addr_x_o) == 1 && $countones(addr_y_o) == 1, "R5 onehot",
            $countones(addr_x_o) * 10 + $countones(addr_y_o), 11);
      got[n_got] = cur_addr();
      n_got++;
    end else begin
      check(addr_x_o == '0 && addr_y_o == '0 && addr_sp_o == '0, "R5 idle zero",
            int'({addr_sp_o, addr_y_o, addr_x_o}), 0);
    end
  endtask

  task automatic collect(input int window);
    n_got = 0;
    for (int i = 0; i < window; i++) begin
      @(negedge clk);
      sample_now(i);
    end
  endtask

  // drive one-cycle pulse; returns at the negedge where input drops
  task automatic pulse(input logic [TOTAL-1:0] v);
    @(negedge clk);
    hit_i = v;
    @(negedge clk);
    hit_i = '0;
  endtask

  task automatic expect_order(input logic [TOTAL-1:0] v, input string tag);
    n_exp = 0;
    for (int i = 0; i < TOTAL; i++) if (v[i]) begin expv[n_exp] = i; n_exp++; end
    check(n_got == n_exp, {tag, " R2 count"}, n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++)
      check(got[k] == expv[k], {tag, " R4 order"}, got[k], expv[k]);
  endtask

  initial begin
    logic [TOTAL-1:0] v;
    int p;
    checks = 0; failures = 0; cyc = 0;
    rst_n = 1'b0; clr_i = 1'b0; hold_i = 1'b0; hit_i = '0;
    lf = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!valid_o && addr_x_o == '0 && addr_y_o == '0 && addr_sp_o == '0,
          "R5 reset state", int'(valid_o), 0);

    // every pixel alone: mapping, latching, latency
    for (int q = 0; q < TOTAL; q++) begin
      v = '0; v[q] = 1'b1;
      pulse(v);
      collect(2);
      check(first_valid, "R9 latency", int'(first_valid), 1);
      check(n_got == 1, "R1 latched hit reported once", n_got, 1);
      check(n_got >= 1 && got[0] == q, "R3 address map", got[0], q);
    end

    // pseudo-random patterns of rising density
    for (int t = 0; t < 12; t++) begin
      v = '0;
      for (int i = 0; i < TOTAL; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (int'(lf[7:0]) < 2 + t * 4) v[i] = 1'b1;
      end
      pulse(v);
      collect($countones(v) + 3);
      expect_order(v, "random");
    end

    // two full super pixels
    v = '0;
    v[63:0] = '1;
    v[TOTAL-1 -: 64] = '1;
    pulse(v);
    collect(134);
    expect_order(v, "dense");

    // hold while the first of three hits is shown
    v = '0; v[5] = 1'b1; v[200] = 1'b1; v[900] = 1'b1;
    pulse(v);
    @(negedge clk);
    check(valid_o && cur_addr() == 5, "R6 first shown", cur_addr(), 5);
    hold_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(valid_o && cur_addr() == 5, "R6 frozen under hold", cur_addr(), 5);
    end
    hold_i = 1'b0;
    collect(5);
    v[5] = 1'b0;
    expect_order(v, "R6 resume");

    // re-hit in the cycle the pixel is being cleared
    p = 300;
    v = '0; v[p] = 1'b1;
    pulse(v);
    @(negedge clk);
    check(valid_o && cur_addr() == p, "R7 shown", cur_addr(), p);
    hit_i[p] = 1'b1;
    @(negedge clk);
    hit_i = '0;
    check(!valid_o, "R7 gap cycle", int'(valid_o), 0);
    collect(4);
    check(n_got == 1, "R7 re-hit kept count", n_got, 1);
    check(n_got >= 1 && got[0] == p, "R7 re-hit address", got[0], p);

    // clear while hits are pending, with a hit in the clear cycle
    v = '0;
    for (int i = 0; i < 10; i++) v[i * 97 + 3] = 1'b1;
    pulse(v);
    @(negedge clk);
    check(valid_o, "R8 pending before clear", int'(valid_o), 1);
    clr_i = 1'b1;
    hit_i[7] = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    hit_i = '0;
    check(!valid_o, "R8 empty after clear", int'(valid_o), 0);
    collect(6);
    check(n_got == 0, "R8 nothing left", n_got, 0);

    // the block works again after a clear
    v = '0; v[1000] = 1'b1; v[64] = 1'b1;
    pulse(v);
    collect(4);
    expect_order(v, "R8 after clear");

    summary();
    $finish;
  end
endmodule